// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet controller and decides whether an incoming frame is kept, based only on its length and its 48-bit destination address. It compares the address against a table of sixteen exact-match entries, all in parallel, and one cycle later it returns a keep/drop decision. The decision comes with two status flags. One says the frame passed only because filtering was switched off. The other says it passed as a multicast frame.

The table is loaded from a setup buffer. Software-built setup data arrives as a byte stream with valid/ready handshaking and a last marker. Each entry sits sparsely in a twelve-byte slot. The block stages the bytes and counts them. It switches the new table in only when the buffer held exactly the expected number of bytes. Four mode inputs shape the decision: promiscuous, receive-all, pass-all-multicast and inverse filtering.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every table entry is all zeros, so an all-zero destination address matches an entry and is accepted when no mode is set.
- R2: A decision (`dec_valid` high for exactly one cycle) appears in the cycle after `frm_valid` is sampled high, and at no other time.
- R3: A frame whose length is below 14 or above 2048 bytes is rejected with both status flags low, whatever its address and the modes.
- R4: The broadcast address (all 48 bits one) is accepted with both status flags low, even when promiscuous or receive-all mode is set.
- R5: When promiscuous or receive-all mode is set, any other length-valid frame is accepted with the filtering-fail flag set and the multicast flag low.
- R6: When pass-all-multicast is set and neither rule R4 nor R5 applies, a frame whose first address byte (`frm_da[7:0]`) has bit 0 set is accepted with the multicast flag set and the filtering-fail flag low.
- R7: Otherwise the frame is accepted, with both flags low, if and only if its address equals one of the sixteen table entries.
- R8: With inverse filtering set, the result of rule R7 is inverted. Rules R3 to R6 are not affected by it.
- R9: A setup buffer of exactly 192 bytes replaces the table. Entry n is taken from bytes 12n to 12n+11. Its address bytes 0..5 (byte 0 compared with `frm_da[7:0]`, byte 5 with `frm_da[47:40]`) come from slot offsets 0, 1, 4, 5, 8 and 9. Offsets 2, 3, 6, 7, 10 and 11 are ignored.
- R10: A setup buffer of any other length, shorter or longer, leaves the table unchanged, and `setup_done` still pulses with `setup_loaded` low.
- R11: `setup_done` pulses for one cycle, two cycles after the edge that accepts the byte marked last. `setup_ready` is low only in the cycle between those two edges. The new table is in use from the cycle in which `setup_done` is high.
- R12: Neither status flag is ever high unless `dec_valid` and `dec_accept` are both high, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_promisc | input | 1 | Promiscuous mode |
| mode_rx_all | input | 1 | Receive-all mode |
| mode_pass_mcast | input | 1 | Accept every multicast frame |
| mode_inverse | input | 1 | Invert the exact-match result |
| setup_valid | input | 1 | Setup byte present |
| setup_ready | output | 1 | Setup byte can be taken |
| setup_data | input | 8 | Setup byte |
| setup_last | input | 1 | Marks the final setup byte |
| setup_done | output | 1 | One-cycle pulse: setup buffer finished |
| setup_loaded | output | 1 | With `setup_done`: the table was replaced |
| frm_valid | input | 1 | Frame length and address present |
| frm_len | input | 16 | Frame length in bytes |
| frm_da | input | 48 | Destination address, first byte in bits 7:0 |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame is kept |
| dec_filter_fail | output | 1 | Kept only because filtering was bypassed |
| dec_mcast | output | 1 | Kept as a pass-all multicast frame |

## Verification
The bench builds the block with its default parameters: sixteen entries, 14- and 2048-byte length limits, and a 16-bit length field. With these values the length boundaries on both sides can be driven, and the full 192-byte setup buffer is streamed within a few hundred cycles. Every table entry is probed with its own address and with a one-bit corruption of it. All sixteen combinations of the four mode bits are swept against broadcast, matched and unmatched unicast, and matched and unmatched multicast addresses. Setup buffers one byte short and one byte long are sent to show that the table survives them.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  // Slot layout of the setup buffer: fixed by the buffer format.
  localparam int SLOT_BYTES = 12;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;

  typedef logic [3:0]      slot_off_t;
  typedef logic [2:0]      byte_pos_t;
  typedef logic [ADDR_W-1:0] mac_t;

  // Offsets 0,1,4,5,8,9 carry address bytes; the rest are padding.
  function automatic logic slot_keep(input slot_off_t off);
    return (off[1] == 1'b0) && (off < slot_off_t'(SLOT_BYTES));
  endfunction

  // Kept offsets map, in order, to address bytes 0..5.
  function automatic byte_pos_t slot_pos(input slot_off_t off);
    return {off[3:2], off[0]};
  endfunction
endpackage

// File: rtl/afilt_setup_loader.sv
module afilt_setup_loader
  import afilt_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      setup_valid,
  input  logic [7:0]                setup_data,
  input  logic                      setup_last,
  output logic                      setup_ready,
  output logic                      commit,
  output logic                      setup_done,
  output logic                      setup_loaded,
  output logic [ENTRIES*ADDR_W-1:0] shadow_flat
);
  localparam int ENT_W = $clog2(ENTRIES + 1);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  slot_off_t        slot_q;
  logic [ENT_W-1:0] ent_q;
  logic             pend_q;
  logic             pend_ok_q;

  // Staging copy: written one byte per cycle, no reset, RAM-friendly.
  logic [7:0] shadow_q [ENTRIES][ADDR_BYTES];

  logic take, slot_end, ent_full, final_byte;
  assign take       = setup_valid && !pend_q;
  assign slot_end   = (slot_q == slot_off_t'(SLOT_BYTES - 1));
  assign ent_full   = (ent_q == ENT_W'(ENTRIES));
  assign final_byte = (ent_q == ENT_W'(ENTRIES - 1)) && slot_end;

  assign setup_ready = !pend_q;
  assign commit      = pend_q && pend_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q       <= '0;
      ent_q        <= '0;
      pend_q       <= 1'b0;
      pend_ok_q    <= 1'b0;
      setup_done   <= 1'b0;
      setup_loaded <= 1'b0;
    end else begin
      pend_q       <= take && setup_last;
      pend_ok_q    <= take && setup_last && final_byte;
      setup_done   <= pend_q;
      setup_loaded <= pend_q && pend_ok_q;
      if (take) begin
        if (setup_last) begin
          slot_q <= '0;
          ent_q  <= '0;
        end else if (slot_end) begin
          slot_q <= '0;
          if (!ent_full) ent_q <= ent_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && !ent_full && slot_keep(slot_q))
      shadow_q[ent_q[IDX_W-1:0]][slot_pos(slot_q)] <= setup_data;
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++)
      for (int b = 0; b < ADDR_BYTES; b++)
        shadow_flat[e*ADDR_W + b*8 +: 8] = shadow_q[e][b];
  end
endmodule

// File: rtl/afilt_cam.sv
module afilt_cam
  import afilt_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      commit,
  input  logic [ENTRIES*ADDR_W-1:0] shadow_flat,
  input  mac_t                      lookup_da,
  output logic                      hit_any
);
  logic [ENTRIES-1:0] hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    mac_t live_q;
    always_ff @(posedge clk) begin
      if (rst)         live_q <= '0;
      else if (commit) live_q <= shadow_flat[e*ADDR_W +: ADDR_W];
    end
    assign hit[e] = (live_q == lookup_da);
  end

  assign hit_any = |hit;
endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
  import afilt_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  mac_t             frm_da,
  input  logic             hit_any,
  input  logic             mode_promisc,
  input  logic             mode_rx_all,
  input  logic             mode_pass_mcast,
  input  logic             mode_inverse,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_filter_fail,
  output logic             dec_mcast
);
  logic len_ok, is_bcast, is_group;
  logic acc_d, ff_d, mf_d;

  assign len_ok   = (frm_len >= LEN_W'(MIN_LEN)) && (frm_len <= LEN_W'(MAX_LEN));
  assign is_bcast = &frm_da;
  assign is_group = frm_da[0];

  // Priority: length, broadcast, bypass modes, multicast, exact match.
  always_comb begin
    acc_d = 1'b0;
    ff_d  = 1'b0;
    mf_d  = 1'b0;
    if (!len_ok) begin
      acc_d = 1'b0;
    end else if (is_bcast) begin
      acc_d = 1'b1;
    end else if (mode_promisc || mode_rx_all) begin
      acc_d = 1'b1;
      ff_d  = 1'b1;
    end else if (mode_pass_mcast && is_group) begin
      acc_d = 1'b1;
      mf_d  = 1'b1;
    end else begin
      acc_d = hit_any ^ mode_inverse;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid       <= 1'b0;
      dec_accept      <= 1'b0;
      dec_filter_fail <= 1'b0;
      dec_mcast       <= 1'b0;
    end else begin
      dec_valid       <= frm_valid;
      dec_accept      <= frm_valid && acc_d;
      dec_filter_fail <= frm_valid && ff_d;
      dec_mcast       <= frm_valid && mf_d;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import afilt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_promisc,
  input  logic             mode_rx_all,
  input  logic             mode_pass_mcast,
  input  logic             mode_inverse,
  input  logic             setup_valid,
  output logic             setup_ready,
  input  logic [7:0]       setup_data,
  input  logic             setup_last,
  output logic             setup_done,
  output logic             setup_loaded,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [47:0]      frm_da,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_filter_fail,
  output logic             dec_mcast
);
  logic                      commit;
  logic                      hit_any;
  logic [ENTRIES*ADDR_W-1:0] shadow_flat;

  afilt_setup_loader #(.ENTRIES(ENTRIES)) u_loader (
    .clk          (clk),
    .rst          (rst),
    .setup_valid  (setup_valid),
    .setup_data   (setup_data),
    .setup_last   (setup_last),
    .setup_ready  (setup_ready),
    .commit       (commit),
    .setup_done   (setup_done),
    .setup_loaded (setup_loaded),
    .shadow_flat  (shadow_flat)
  );

  afilt_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit),
    .shadow_flat (shadow_flat),
    .lookup_da   (frm_da),
    .hit_any     (hit_any)
  );

  afilt_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_decide (
    .clk             (clk),
    .rst             (rst),
    .frm_valid       (frm_valid),
    .frm_len         (frm_len),
    .frm_da          (frm_da),
    .hit_any         (hit_any),
    .mode_promisc    (mode_promisc),
    .mode_rx_all     (mode_rx_all),
    .mode_pass_mcast (mode_pass_mcast),
    .mode_inverse    (mode_inverse),
    .dec_valid       (dec_valid),
    .dec_accept      (dec_accept),
    .dec_filter_fail (dec_filter_fail),
    .dec_mcast       (dec_mcast)
  );
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 2048
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_promisc,
  input logic             mode_rx_all,
  input logic             setup_valid,
  input logic             setup_ready,
  input logic             setup_last,
  input logic             setup_done,
  input logic             setup_loaded,
  input logic             frm_valid,
  input logic [LEN_W-1:0] frm_len,
  input logic [47:0]      frm_da,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic             dec_filter_fail,
  input logic             dec_mcast
);
  logic len_bad;
  assign len_bad = (frm_len < LEN_W'(MIN_LEN)) || (frm_len > LEN_W'(MAX_LEN));

  p_pulse_on_req_r2: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> dec_valid);
  p_quiet_no_req_r2: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !dec_valid);
  p_len_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && len_bad) |=> (!dec_accept && !dec_filter_fail && !dec_mcast));
  p_bcast_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !len_bad && (&frm_da)) |=> (dec_accept && !dec_filter_fail && !dec_mcast));
  p_bypass_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !len_bad && !(&frm_da) && (mode_promisc || mode_rx_all))
      |=> (dec_accept && dec_filter_fail));
  p_done_after_last_r11: assert property (@(posedge clk) disable iff (rst)
    (setup_valid && setup_ready && setup_last) |=> (!setup_ready && !setup_done));
  p_ready_gap_r11: assert property (@(posedge clk) disable iff (rst)
    !setup_ready |=> (setup_done && setup_ready));
  p_loaded_in_done_r10: assert property (@(posedge clk) disable iff (rst)
    setup_loaded |-> setup_done);
  p_flags_need_accept_r12: assert property (@(posedge clk) disable iff (rst)
    (dec_filter_fail || dec_mcast) |-> (dec_valid && dec_accept));
  p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(dec_filter_fail && dec_mcast));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(
  .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rst(rst), .mode_promisc(mode_promisc), .mode_rx_all(mode_rx_all),
  .setup_valid(setup_valid), .setup_ready(setup_ready), .setup_last(setup_last),
  .setup_done(setup_done), .setup_loaded(setup_loaded), .frm_valid(frm_valid),
  .frm_len(frm_len), .frm_da(frm_da), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .dec_filter_fail(dec_filter_fail), .dec_mcast(dec_mcast)
);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NENT  = 16;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_promisc = 0, mode_rx_all = 0, mode_pass_mcast = 0, mode_inverse = 0;
  logic setup_valid = 0, setup_last = 0;
  logic [7:0] setup_data = '0;
  logic setup_ready, setup_done, setup_loaded;
  logic frm_valid = 0;
  logic [LEN_W-1:0] frm_len = '0;
  logic [47:0] frm_da = '0;
  logic dec_valid, dec_accept, dec_filter_fail, dec_mcast;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst(rst),
    .mode_promisc(mode_promisc), .mode_rx_all(mode_rx_all),
    .mode_pass_mcast(mode_pass_mcast), .mode_inverse(mode_inverse),
    .setup_valid(setup_valid), .setup_ready(setup_ready), .setup_data(setup_data),
    .setup_last(setup_last), .setup_done(setup_done), .setup_loaded(setup_loaded),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_da(frm_da),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_filter_fail(dec_filter_fail), .dec_mcast(dec_mcast)
  );

  int checks = 0;
  int errors = 0;
  logic [47:0] tb_tab [NENT];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] gen_addr(input int seed, input int e);
    logic [7:0] b0;
    b0 = 8'(e*2 + seed*4 + 2);
    if (e == 5) b0[0] = 1'b1;
    return {8'(e*3 + 1), 8'hC0 ^ 8'(seed), 8'(e), 8'(seed*11 + 1), 8'(e*37 + seed), b0};
  endfunction

  // Expected decision from R3..R8; returns {accept, ff, mf} and the rule tag.
  task automatic model(input logic [47:0] da, input int len, input logic [3:0] m,
                       output logic [2:0] res, output string tag);
    logic hit;
    hit = 1'b0;
    for (int e = 0; e < NENT; e++) if (tb_tab[e] == da) hit = 1'b1;
    if (len < 14 || len > 2048)      begin res = 3'b000; tag = "R3"; end
    else if (&da)                    begin res = 3'b100; tag = "R4"; end
    else if (m[0] || m[1])           begin res = 3'b110; tag = "R5"; end
    else if (m[2] && da[0])          begin res = 3'b101; tag = "R6"; end
    else if (m[3])                   begin res = {~hit, 2'b00}; tag = "R8"; end
    else                             begin res = {hit, 2'b00}; tag = "R7"; end
  endtask

  task automatic query(input logic [47:0] da, input int len, input logic [3:0] m,
                       input string note);
    logic [2:0] exp;
    string tag;
    @(negedge clk);
    frm_valid = 1'b1; frm_da = da; frm_len = LEN_W'(len);
    {mode_inverse, mode_pass_mcast, mode_rx_all, mode_promisc} = m;
    @(negedge clk);
    frm_valid = 1'b0;
    model(da, len, m, exp, tag);
    check("R2", {note, " valid"}, int'(dec_valid), 1);
    check(tag, {note, " accept"}, int'(dec_accept), int'(exp[2]));
    check(tag, {note, " filter_fail"}, int'(dec_filter_fail), int'(exp[1]));
    check(tag, {note, " mcast"}, int'(dec_mcast), int'(exp[0]));
    @(negedge clk);
    check("R2", {note, " idle"}, int'(dec_valid), 0);
  endtask

  // Stream a setup buffer of nbytes built from seed; filler at padding offsets.
  task automatic send_setup(input int seed, input int nbytes, input logic expect_load);
    logic [47:0] a;
    for (int k = 0; k < nbytes; k++) begin
      int e, off;
      e = k / 12; off = k % 12;
      @(negedge clk);
      while (!setup_ready) @(negedge clk);
      setup_valid = 1'b1;
      setup_last  = (k == nbytes - 1);
      if (e < NENT && (off % 4) < 2) begin
        a = gen_addr(seed, e);
        setup_data = a[((off/4)*2 + off%2)*8 +: 8];
      end else begin
        setup_data = 8'(8'h5A ^ k);
      end
    end
    @(negedge clk);
    setup_valid = 1'b0; setup_last = 1'b0;
    check("R11", "ready low after last", int'(setup_ready), 0);
    check("R11", "done not yet", int'(setup_done), 0);
    @(negedge clk);
    check("R11", "done pulse", int'(setup_done), 1);
    check(expect_load ? "R9" : "R10", "loaded flag", int'(setup_loaded), int'(expect_load));
    check("R11", "ready back", int'(setup_ready), 1);
    if (expect_load) for (int e = 0; e < NENT; e++) tb_tab[e] = gen_addr(seed, e);
    @(negedge clk);
    check("R11", "done single cycle", int'(setup_done), 0);
  endtask

  initial begin
    logic [47:0] cls [5];
    for (int e = 0; e < NENT; e++) tb_tab[e] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R2", "reset dec_valid", int'(dec_valid), 0);
    check("R11", "reset setup_done", int'(setup_done), 0);
    check("R11", "reset setup_ready", int'(setup_ready), 1);

    // R1: zero table matches the zero address
    query(48'h0, 64, 4'b0000, "R1 zero addr after reset");

    // R9: full load, then per-entry probing
    send_setup(1, 192, 1'b1);
    for (int e = 0; e < NENT; e++) begin
      query(tb_tab[e], 60, 4'b0000, "R9 entry exact");
      query(tb_tab[e] ^ (48'h1 << ((e*7 + 8) % 48)), 60, 4'b0000, "R7 entry corrupted");
    end
    query(48'h0, 64, 4'b0000, "R9 zero no longer present");

    // Mode sweep over address classes
    cls[0] = 48'hFFFF_FFFF_FFFF;
    cls[1] = tb_tab[3];
    cls[2] = tb_tab[5];
    cls[3] = 48'h0012_3456_789A;
    cls[4] = 48'h0012_3456_789B;
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 5; c++)
        query(cls[c], 100, 4'(m), "R8 mode sweep");

    // R3: length boundaries, across overriding conditions
    foreach (cls[c]) begin
      int lens [8] = '{0, 13, 14, 15, 2047, 2048, 2049, 65535};
      foreach (lens[i]) query(cls[c], lens[i], 4'b0101, "R3 length");
    end

    // R10: short and long buffers keep the table
    send_setup(2, 191, 1'b0);
    query(gen_addr(1, 0), 64, 4'b0000, "R10 old entry kept (short)");
    query(gen_addr(2, 0), 64, 4'b0000, "R10 new entry absent (short)");
    send_setup(2, 193, 1'b0);
    query(gen_addr(1, 15), 64, 4'b0000, "R10 old entry kept (long)");
    query(gen_addr(2, 15), 64, 4'b0000, "R10 new entry absent (long)");
    send_setup(2, 192, 1'b1);
    query(gen_addr(1, 7), 64, 4'b0000, "R9 old entry replaced");
    query(gen_addr(2, 7), 64, 4'b0000, "R9 new entry present");
    query(gen_addr(2, 7), 64, 4'b1000, "R8 inverse on match");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule